// File: doc/BRIEF.md
# External interrupt request flag register

This block keeps one sticky request flag for each of fifteen external interrupt lines. Every line has its own 2-bit sense setting that decides which pin condition raises its flag: a low level, a falling edge, a rising edge, or either edge. The request pins are asynchronous. Each one passes through a two-stage synchroniser before any detection, and edges are found by comparing the synchronised level with its value one clock earlier.

Software sees the flags as a 16-bit register. A read shows every flag at once. A write can only clear flags: a 0 clears a flag and a 1 leaves it alone. A clear is accepted only after software has read that flag as 1, and the block tracks this with a per-flag read marker. The CPU also reports the start of exception handling for a line through an acknowledge strobe. In the edge modes the acknowledge clears the flag. In level mode it clears the flag only if the synchronised pin is already high again. When a new set event meets a clear in the same cycle, the set wins.

Top module: `irq_flag_reg`

## Requirements
- R1: After reset every flag is 0 and the register reads 16'h0000.
- R2: Bit 15 of the register always reads 0, and writing it has no effect.
- R3: With sense code 2'b00 (low level), a flag is set while its synchronised line is low. The flag is visible on the third rising edge after the pin changes.
- R4: With sense code 2'b01 (falling edge), only a high-to-low transition sets the flag. A rising transition leaves it unchanged.
- R5: With sense code 2'b10 (rising edge), only a low-to-high transition sets the flag. A falling transition leaves it unchanged.
- R6: With sense code 2'b11 (both edges), either transition sets the flag.
- R7: Writing 1 to a flag bit never sets it and never clears it.
- R8: Writing 0 to bit n clears flag n only if a read (rd_en) returned bit n as 1 beforehand. Without such a read, the flag stays set.
- R9: In the edge modes, an acknowledge (ack_valid with ack_line = n) clears flag n on the next edge.
- R10: In low-level mode, an acknowledge clears flag n only if the synchronised line is high. Otherwise the flag stays set.
- R11: A set event in the same cycle as a software or acknowledge clear leaves the flag set.
- R12: An acknowledge for one line leaves every other flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pin | input | 15 | Asynchronous request lines |
| sense_mode | input | 30 | 2-bit sense code per line; line n uses bits [2n+1:2n] |
| ack_valid | input | 1 | Exception handling for one line has started |
| ack_line | input | 4 | Index of the acknowledged line |
| rd_en | input | 1 | Register read strobe; arms the read markers |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Write data; a 0 bit requests a clear |
| rd_data | output | 16 | Register contents; bits 14:0 are the flags, bit 15 is 0 |

## Verification
A pin change takes three rising edges to reach the register: two synchroniser stages, then the flag flop. The bench changes pins on a falling edge and samples three falling edges later. In one case it also samples after two edges, to show that the flag is not yet set. Writes and acknowledges are applied for one cycle and take effect on the next rising edge, so the bench reads the result at the following falling edge. The same-cycle set/clear case places the write in the cycle in which the synchronised edge appears, which is two edges after the pin change.

// File: rtl/irq_flag_reg.sv
module irq_flag_reg #(
  parameter int NLINES = 15,
  parameter int REGW   = 16,
  localparam int IDW   = $clog2(NLINES),
  localparam int MW    = 2 * NLINES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] irq_pin,
  input  logic [MW-1:0]     sense_mode,
  input  logic              ack_valid,
  input  logic [IDW-1:0]    ack_line,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [REGW-1:0]   wr_data,
  output logic [REGW-1:0]   rd_data
);

  logic [NLINES-1:0] meta, lvl, lvl_q;
  logic [NLINES-1:0] flag, armed, set_ev, clr_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta  <= '1;
      lvl   <= '1;
      lvl_q <= '1;
    end else begin
      meta  <= irq_pin;
      lvl   <= meta;
      lvl_q <= lvl;
    end
  end

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    logic [1:0] m;
    logic       fall, rise, sw_clr, ak_clr;
    assign m      = sense_mode[2*i +: 2];
    assign fall   = lvl_q[i] & ~lvl[i];
    assign rise   = ~lvl_q[i] & lvl[i];
    assign set_ev[i] = (m == 2'b00) ? ~lvl[i] :
                       (m == 2'b01) ? fall :
                       (m == 2'b10) ? rise : (fall | rise);
    assign sw_clr = wr_en & ~wr_data[i] & armed[i];
    assign ak_clr = ack_valid & (ack_line == IDW'(i)) & ((m != 2'b00) | lvl[i]);
    assign clr_ev[i] = sw_clr | ak_clr;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag[i]  <= 1'b0;
        armed[i] <= 1'b0;
      end else begin
        flag[i] <= set_ev[i] | (flag[i] & ~clr_ev[i]);
        if (clr_ev[i])            armed[i] <= 1'b0;
        else if (rd_en & flag[i]) armed[i] <= 1'b1;
      end
    end
  end

  assign rd_data = REGW'(flag);

endmodule

// File: rtl/irq_flag_reg_chk.sv
module irq_flag_reg_chk #(
  parameter int NLINES = 15,
  parameter int REGW   = 16,
  localparam int IDW   = $clog2(NLINES)
) (
  input logic                clk,
  input logic                rst_n,
  input logic [2*NLINES-1:0] sense_mode,
  input logic                ack_valid,
  input logic [IDW-1:0]      ack_line,
  input logic                wr_en,
  input logic [REGW-1:0]     rd_data,
  input logic [NLINES-1:0]   flag,
  input logic [NLINES-1:0]   armed,
  input logic [NLINES-1:0]   set_ev,
  input logic [NLINES-1:0]   lvl
);

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n) rd_data[REGW-1:NLINES] == '0) else $error("reserved bits"); // R2

  for (genvar i = 0; i < NLINES; i++) begin : g_chk
    logic ack_me;
    assign ack_me = ack_valid && (ack_line == IDW'(i));

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n) set_ev[i] |=> flag[i]) else $error("set lost"); // R11
    AST_NO_CLR_UNREAD: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && !armed[i] && flag[i] && !ack_me) |=> flag[i]) else $error("unread clear"); // R8
    AST_MARK_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n) armed[i] |-> flag[i]) else $error("marker without flag"); // R8
    AST_EDGE_ACK_CLR: assert property (@(posedge clk) disable iff (!rst_n) (ack_me && sense_mode[2*i +: 2] != 2'b00 && !set_ev[i]) |=> !flag[i]) else $error("edge ack"); // R9
    AST_LVL_ACK_KEEP: assert property (@(posedge clk) disable iff (!rst_n) (ack_me && sense_mode[2*i +: 2] == 2'b00 && flag[i] && !lvl[i]) |=> flag[i]) else $error("level ack"); // R10
  end

endmodule

bind irq_flag_reg irq_flag_reg_chk #(.NLINES(NLINES), .REGW(REGW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sense_mode(sense_mode), .ack_valid(ack_valid),
  .ack_line(ack_line), .wr_en(wr_en), .rd_data(rd_data), .flag(flag),
  .armed(armed), .set_ev(set_ev), .lvl(lvl)
);

// File: tb/irq_flag_reg_tb_top.sv
module irq_flag_reg_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [14:0] irq_pin = '1;
  logic [29:0] sense_mode = {15{2'b01}};
  logic        ack_valid = 1'b0;
  logic [3:0]  ack_line = '0;
  logic        rd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '1;
  logic [15:0] rd_data;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_flag_reg dut_i (.*);

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_bit(input int n, input bit e, input string req);
    check(rd_data[n] === e, req, 16'(rd_data[n]), 16'(e));
  endtask

  task automatic cyc(input int k);
    for (int j = 0; j < k; j++) @(negedge clk);
  endtask

  task automatic set_mode(input int n, input logic [1:0] m);
    sense_mode[2*n +: 2] = m;
  endtask

  task automatic pin(input int n, input bit v);
    irq_pin[n] = v;
    cyc(3);
  endtask

  task automatic ack(input int n);
    ack_valid = 1'b1; ack_line = 4'(n);
    cyc(1);
    ack_valid = 1'b0;
  endtask

  task automatic rd();
    rd_en = 1'b1; cyc(1); rd_en = 1'b0;
  endtask

  task automatic wr(input logic [15:0] d);
    wr_en = 1'b1; wr_data = d; cyc(1); wr_en = 1'b0; wr_data = '1;
  endtask

  task automatic t_reset();
    check(rd_data === 16'h0000, "R1", rd_data, 16'h0000);
  endtask

  task automatic t_falling();
    irq_pin[3] = 1'b0;
    cyc(2); chk_bit(3, 0, "R3 latency");
    cyc(1); chk_bit(3, 1, "R4 falling set");
    ack(3); chk_bit(3, 0, "R9 edge ack");
    pin(3, 1); cyc(1); chk_bit(3, 0, "R4 rising ignored");
  endtask

  task automatic t_rising();
    set_mode(5, 2'b10); cyc(1);
    pin(5, 0); cyc(1); chk_bit(5, 0, "R5 falling ignored");
    pin(5, 1); chk_bit(5, 1, "R5 rising set");
    ack(5); chk_bit(5, 0, "R9 rising ack");
  endtask

  task automatic t_both();
    set_mode(7, 2'b11); cyc(1);
    pin(7, 0); chk_bit(7, 1, "R6 fall");
    ack(7); chk_bit(7, 0, "R9 both ack");
    pin(7, 1); chk_bit(7, 1, "R6 rise");
    ack(7); chk_bit(7, 0, "R9 both ack2");
  endtask

  task automatic t_level();
    set_mode(9, 2'b00); cyc(4);
    chk_bit(9, 0, "R3 high idle");
    pin(9, 0); chk_bit(9, 1, "R3 low set");
    ack(9); chk_bit(9, 1, "R10 ack while low");
    pin(9, 1); chk_bit(9, 1, "R3 sticky");
    ack(9); chk_bit(9, 0, "R10 ack while high");
  endtask

  task automatic t_swclr();
    pin(2, 0);
    chk_bit(2, 1, "R4 set line2");
    wr(16'hFFFB); chk_bit(2, 1, "R8 unread write0");
    rd_en = 1'b1; chk_bit(2, 1, "R8 read sees 1"); cyc(1); rd_en = 1'b0;
    wr(16'hFFFF); chk_bit(2, 1, "R7 write1 keeps");
    wr(16'hFFFB); chk_bit(2, 0, "R8 read then write0");
    pin(2, 1);
  endtask

  task automatic t_rsvd();
    wr(16'h8000); check(rd_data === 16'h0000, "R2 bit15 write", rd_data, 16'h0000);
    wr(16'h7FFF); check(rd_data === 16'h0000, "R7 write1 no set", rd_data, 16'h0000);
  endtask

  task automatic t_setwins();
    pin(4, 0); pin(4, 1);
    chk_bit(4, 1, "R4 line4");
    rd();
    irq_pin[4] = 1'b0;
    cyc(2);
    wr(16'hFFEF);
    chk_bit(4, 1, "R11 set wins sw");
    rd();
    pin(4, 1);
    irq_pin[4] = 1'b0;
    cyc(2);
    ack(4);
    chk_bit(4, 1, "R11 set wins ack");
    ack(4); chk_bit(4, 0, "R9 line4 clear");
    pin(4, 1);
  endtask

  task automatic t_other();
    pin(6, 0);
    ack(8); chk_bit(6, 1, "R12 other ack");
    check(rd_data === 16'h0040, "R12 only line6", rd_data, 16'h0040);
    ack(6); chk_bit(6, 0, "R9 line6");
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    t_reset();
    t_falling();
    t_rising();
    t_both();
    t_level();
    t_swclr();
    t_rsvd();
    t_setwins();
    t_other();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule